// File: doc/BRIEF.md
# Chainable 16-bit Serial Command Register Slave

This block is the serial front end of a two-channel actuator controller. A host writes 16-bit command frames over a four-wire serial link, most significant bit first, while chip select is held low. Input bits are taken on the falling edge of the serial clock. When chip select is released, the three top bits of the last frame pick one of six command registers, and the remaining thirteen bits are stored there. The registers drive the rest of the controller.

On the same link the block returns a status word. The word is chosen by a field in register 0 and is loaded on the first rising serial clock edge of a transfer. A transfer may run for any whole number of 16-bit frames, so several such slaves can be chained. Once the status word has gone out, the output repeats the bits that came in since chip select fell, in arrival order. Transfers of any other length write nothing.

All pins are brought into the system clock domain through two-stage synchronisers, and edges are found in that domain. The serial clock must therefore be several times slower than the system clock.

Top module: `chain_spi_regs`

## Requirements
- R1: After reset every register holds zero, `drv_en` is 0 and `miso_oe` is 0.
- R2: A 16-bit transfer whose bits 15:13 hold an address 0 to 5 stores bits 12:0 into that register. Address 0 is the power/enable/config register, 1 the maximum velocity, 2 and 3 the channel 0 and channel 1 positions, 4 the return-to-zero command and 5 the return-to-zero setup.
- R3: No register changes while chip select is low. The write lands one system cycle after the synchronised chip select rises.
- R4: A transfer of 1 to 15 bits changes no register.
- R5: A transfer longer than 16 bits whose length is not a multiple of 16 changes no register.
- R6: A transfer of 16·k bits (k > 1) stores only its last 16 bits, decoded as in R2.
- R7: Frames addressed to 6 or 7 change no register.
- R8: The first 16 bits on `miso` are status word s, most significant bit first. Here s is bits 3:2 of register 0, and word s is `stat_in[16*s+15:16*s]`.
- R9: From bit 17 onward, `miso` repeats the `mosi` bits received since chip select fell, in the same order.
- R10: `miso_oe` is 1 while the synchronised chip select is low and 0 while it is high.
- R11: `drv_en[0]` and `drv_en[1]` equal bits 0 and 1 of register 0 (1 enables that channel's driver).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| stat_in | input | 64 | Four 16-bit status words, word k at bits 16k+15:16k |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso (tri-state control) |
| regs_flat | output | 78 | Six 13-bit registers, register k at bits 13k+12:13k |
| drv_en | output | 2 | Per-channel driver enables |

## Verification
The bench builds the block with its default values: 16-bit frames, a 3-bit address, six registers and four status words. At these values every address can be swept with several payloads. Every short length from 1 to 15 bits can be tried, along with off-multiple lengths just above one and two frames. Every status selector value is tried in a two-frame chained transfer, so each status word and the pass-through path are compared bit by bit.

// File: rtl/chain_spi_pkg.sv
// Package: shared frame geometry and the register address names.
// Assumes a frame is always addressed by its top ADDR_W bits.
package chain_spi_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 3;
    localparam int PAY_W   = FRAME_W - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PWRCFG  = 3'd0,
        ADR_VMAX    = 3'd1,
        ADR_POS_CH0 = 3'd2,
        ADR_POS_CH1 = 3'd3,
        ADR_ZERO    = 3'd4,
        ADR_ZEROCFG = 3'd5,
        ADR_SPARE   = 3'd6,
        ADR_TEST    = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each bit is independent; the reset value is set per bit.
module spi_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // Purpose: move the pins through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_edge_detect.sv
// Module: synchronises sclk, cs_n and mosi and flags their edges in the clk domain.
// Assumes sclk is at least about 4x slower than clk; mosi is delayed exactly like sclk.
module spi_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active,
    output logic mosi_s
);
    logic [2:0] pins_s;
    logic       sclk_d, csn_d;

    spi_pin_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, cs_n, sclk}),
        .dout (pins_s)
    );

    // Purpose: keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= pins_s[0];
            csn_d  <= pins_s[1];
        end
    end

    assign sclk_rise = pins_s[0] & ~sclk_d;
    assign sclk_fall = ~pins_s[0] & sclk_d;
    assign cs_fall   = ~pins_s[1] & csn_d;
    assign cs_rise   = pins_s[1] & ~csn_d;
    assign cs_active = ~pins_s[1];
    assign mosi_s    = pins_s[2];
endmodule

// File: rtl/spi_frame_engine.sv
// Module: input/output shift registers, frame-length check and commit strobe.
// Assumes edge pulses are one clk wide and that cs and sclk edges never coincide.
module spi_frame_engine #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               cs_active,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] status_word,
    output logic               miso,
    output logic               miso_oe,
    output logic               commit,
    output logic [FRAME_W-1:0] frame_q
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   bit_cnt;
    logic               seen_full;
    logic [FRAME_W-1:0] shift_in;
    logic [FRAME_W-1:0] shift_out;
    logic               first_pend;
    logic               oe_q;

    // Purpose: capture mosi on falling sclk and count bits modulo the frame width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            seen_full <= 1'b0;
            shift_in  <= '0;
        end else if (cs_fall) begin
            bit_cnt   <= '0;
            seen_full <= 1'b0;
        end else if (cs_active && sclk_fall) begin
            shift_in <= {shift_in[FRAME_W-2:0], mosi_s};
            if (bit_cnt == LAST) begin
                bit_cnt   <= '0;
                seen_full <= 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Purpose: load status first, then pass earlier input through on each frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_out  <= '0;
            first_pend <= 1'b0;
        end else if (cs_fall) begin
            first_pend <= 1'b1;
        end else if (cs_active && sclk_rise) begin
            first_pend <= 1'b0;
            if (first_pend)
                shift_out <= status_word;
            else if (seen_full && bit_cnt == '0)
                shift_out <= shift_in;
            else
                shift_out <= {shift_out[FRAME_W-2:0], 1'b0};
        end
    end

    // Purpose: drive the output enable and the one-cycle commit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            commit <= 1'b0;
        end else begin
            oe_q   <= cs_active;
            commit <= cs_rise && seen_full && (bit_cnt == '0);
        end
    end

    assign miso    = shift_out[FRAME_W-1];
    assign miso_oe = oe_q;
    assign frame_q = shift_in;

    p_fall_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (bit_cnt == '0 && !seen_full));
    p_short_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !seen_full) |=> !commit);
    p_partial_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt != '0) |=> !commit);
    p_oe_on_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> miso_oe);
    p_oe_off_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe);
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: register file written by address decode of a committed frame.
// Assumes addresses at or above N_REGS are not backed by storage and are dropped.
module cfg_reg_bank #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_W,
    parameter int ADDR_W  = chain_spi_pkg::ADDR_W,
    parameter int N_REGS  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [FRAME_W-1:0]                frame,
    output logic [N_REGS*(FRAME_W-ADDR_W)-1:0] regs_flat
);
    localparam int PAY_W = FRAME_W - ADDR_W;

    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  payload;
    logic [PAY_W-1:0]  regs_q [N_REGS];

    assign addr    = frame[FRAME_W-1 -: ADDR_W];
    assign payload = frame[PAY_W-1:0];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        // Purpose: store the payload when this register is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && addr == ADDR_W'(g))
                regs_q[g] <= payload;
        end
        assign regs_flat[g*PAY_W +: PAY_W] = regs_q[g];
    end

    p_hold_unless_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
    p_unmapped_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ADDR_W'(N_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/chain_spi_regs.sv
// Module: top of the serial command slave; ties sync, frame engine and registers.
// Assumes register 0 carries the channel enables in its low bits and the status selector above them.
module chain_spi_regs #(
    parameter int FRAME_W = chain_spi_pkg::FRAME_W,
    parameter int ADDR_W  = chain_spi_pkg::ADDR_W,
    parameter int N_REGS  = 6,
    parameter int N_CH    = 2,
    parameter int N_STAT  = 4,
    parameter int STAGES  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sclk,
    input  logic                               cs_n,
    input  logic                               mosi,
    input  logic [N_STAT*FRAME_W-1:0]          stat_in,
    output logic                               miso,
    output logic                               miso_oe,
    output logic [N_REGS*(FRAME_W-ADDR_W)-1:0] regs_flat,
    output logic [N_CH-1:0]                    drv_en
);
    localparam int PAY_W   = FRAME_W - ADDR_W;
    localparam int SEL_W   = $clog2(N_STAT);
    localparam int SEL_LSB = N_CH;

    logic               sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active, mosi_s;
    logic               commit;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] status_word;
    logic [PAY_W-1:0]   reg0;
    logic [SEL_W-1:0]   stat_sel;

    spi_edge_detect #(.STAGES(STAGES)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .cs_active(cs_active),
        .mosi_s   (mosi_s)
    );

    spi_frame_engine #(.FRAME_W(FRAME_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .cs_active  (cs_active),
        .mosi_s     (mosi_s),
        .status_word(status_word),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .commit     (commit),
        .frame_q    (frame_q)
    );

    cfg_reg_bank #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .frame    (frame_q),
        .regs_flat(regs_flat)
    );

    assign reg0        = regs_flat[PAY_W-1:0];
    assign stat_sel    = reg0[SEL_LSB +: SEL_W];
    assign status_word = stat_in[int'(stat_sel)*FRAME_W +: FRAME_W];
    assign drv_en      = reg0[N_CH-1:0];
endmodule

// File: tb/tb_chain_spi_regs.sv
module tb_chain_spi_regs;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [63:0] stat_in;
    logic        miso, miso_oe;
    logic [77:0] regs_flat;
    logic [1:0]  drv_en;

    int vectors = 0;
    int fails   = 0;
    logic [12:0] mdl [6];

    always #10 clk = ~clk;

    chain_spi_regs dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .stat_in(stat_in), .miso(miso), .miso_oe(miso_oe),
        .regs_flat(regs_flat), .drv_en(drv_en)
    );

    function automatic logic [15:0] stat_word(int k);
        return 16'hC3A5 ^ 16'(k * 16'h2D1B);
    endfunction

    function automatic logic [77:0] mdl_flat();
        logic [77:0] f;
        for (int i = 0; i < 6; i++) f[i*13 +: 13] = mdl[i];
        return f;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one transfer of nbits, bit j being d[nbits-1-j]
    task automatic xfer(int nbits, logic [63:0] d);
        logic [15:0] st;
        logic        ok;
        logic        act_b, exp_b;
        int          bad_j;
        st = stat_word(int'(mdl[0][3:2]));
        ok = 1'b1; act_b = 1'b0; exp_b = 1'b0; bad_j = 0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk("R10 oe during select", 128'(miso_oe), 128'(1));
        for (int j = 0; j < nbits; j++) begin
            mosi = d[nbits-1-j];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (j < 16 || nbits % 16 == 0 || j < 16 * (nbits / 16)) begin
                logic e;
                e = (j < 16) ? st[15-j] : d[nbits-1-(j-16)];
                if (miso !== e && ok) begin
                    ok = 1'b0; act_b = miso; exp_b = e; bad_j = j;
                end
            end
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        if (!ok) begin
            fails++;
            $display("FAIL R8/R9 miso bit %0d of %0d-bit transfer actual=%0b expected=%0b",
                     bad_j, nbits, act_b, exp_b);
        end
        vectors++;
        chk("R3 no write while selected", 128'(regs_flat), 128'(mdl_flat()));
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        if (nbits > 0 && nbits % 16 == 0 && d[15:13] < 3'd6)
            mdl[d[15:13]] = d[12:0];
        if (nbits < 16)
            chk("R4 short transfer", 128'(regs_flat), 128'(mdl_flat()));
        else if (nbits % 16 != 0)
            chk("R5 off-multiple transfer", 128'(regs_flat), 128'(mdl_flat()));
        else if (nbits > 16)
            chk("R6 chained last frame", 128'(regs_flat), 128'(mdl_flat()));
        else if (d[15:13] >= 3'd6)
            chk("R7 unmapped address", 128'(regs_flat), 128'(mdl_flat()));
        else
            chk("R2 register write", 128'(regs_flat), 128'(mdl_flat()));
        chk("R11 driver enables", 128'(drv_en), 128'(mdl[0][1:0]));
        chk("R10 oe idle", 128'(miso_oe), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) stat_in[k*16 +: 16] = stat_word(k);
        for (int i = 0; i < 6; i++) mdl[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 regs after reset", 128'(regs_flat), 128'(0));
        chk("R1 drv_en after reset", 128'(drv_en), 128'(0));
        chk("R1 oe after reset", 128'(miso_oe), 128'(0));

        // R2 R7 R8 R11: every address with several payloads
        for (int a = 0; a < 8; a++) begin
            xfer(16, 64'({3'(a), 13'h1FFF}));
            xfer(16, 64'({3'(a), 13'h0A55 ^ 13'(a)}));
            xfer(16, 64'({3'(a), 13'h1532 + 13'(a * 7)}));
        end
        // R4: every short length
        for (int n = 1; n < 16; n++) xfer(n, 64'hFFFF_FFFF_FFFF_FFFF);
        // R5: lengths that are not whole frames
        xfer(17, 64'h1_35AB);
        xfer(20, 64'h2_B5F0);
        xfer(31, 64'h5A5A_3FFF);
        xfer(33, 64'h1_0000_5432);
        xfer(47, 64'h1234_4321_5AA5);
        // R6 R8 R9: chained transfers with each status selector
        for (int s = 0; s < 4; s++) begin
            xfer(16, 64'({3'd0, 9'h0, 2'(s), 2'(s ^ 1)}));
            xfer(32, 64'({16'hE00F ^ 16'(s), 3'd2, 13'h0F0F + 13'(s)}));
            xfer(48, 64'({16'h9C31, 16'h6A5B ^ 16'(s * 3), 3'd5, 13'h1ABC ^ 13'(s)}));
        end
        xfer(32, 64'({16'h2222, 3'd7, 13'h1111}));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule